// File: doc/BRIEF.md
# Selective TLB Invalidation Engine

This block owns the valid bits of a small translation buffer made of two register-based arrays. Array 0 is set-associative: 4 ways by 16 sets, with the set chosen by the low page-number bits. Array 1 is fully associative and has 16 entries. An invalidate command names one of three modes. The engine then walks the arrays and clears the valid bit of every entry the mode selects. The walk examines one entry per clock.

The command arrives on a valid/ready interface. `cmd_ready` is high only while the engine is idle. A command offered while the engine is busy waits, because no transfer takes place until `cmd_ready` returns. Each accepted command ends with a one-cycle `done` pulse. An error flag is raised together with that pulse when the command was refused.

A side port writes entries and reads them back. It exists only to load and inspect the arrays.

Entry encoding (42 bits, on `ld_data` and `rd_data`), from high bit to low bit:
- [41] valid
- [40] protect: the entry is kept by the selective modes
- [39] indirect attribute
- [38] guest-state attribute
- [37:24] 14-bit tag ID
- [23:20] 4-bit size code
- [19:0] 20-bit page number

An entry covering size code s spans 2^s pages. Its low s page-number bits are therefore ignored when addresses are compared.

Top module: `tlb_inval_engine`

## Requirements
- R1: After reset every entry reads back with valid=0, `cmd_ready`=1, and `done`, `err_illegal` and `err_priv` are 0.
- R2: Kind 0, from supervisor state, clears the valid bit of every entry, including protected entries, at the edge that accepts the command. `done` is high during the following cycle.
- R3: Kind 1 clears an entry only when its tag ID equals `cmd_pid` exactly and its protect bit is 0. It examines all 80 entries, one per cycle, so `done` is high during the cycle that begins 80 edges after acceptance.
- R4: Kind 3 clears an entry only when all of the following hold:
  - it is valid;
  - its tag ID is 0 or equals `cmd_pid`;
  - its page number equals `cmd_epn` with both values masked by the entry's size code;
  - its protect bit is 0;
  - its indirect bit equals `cmd_sind`;
  - its guest-state bit equals `cmd_sgs`.
- R5: Kind 3 examines in array 0 only the 4 ways of set `cmd_epn[3:0]`, namely indices set*4+way. It examines all 16 entries of array 1, so `done` comes 20 edges after acceptance.
- R6: Kind 2 from supervisor state changes no entry and gives `done` with `err_illegal`=1 in the cycle after acceptance.
- R7: Any command with `cmd_user`=1 changes no entry and gives `done` with `err_priv`=1 and `err_illegal`=0 in the cycle after acceptance. This holds even for kind 2.
- R8: Clearing an entry changes only its valid bit; all other fields keep their values.
- R9: `cmd_ready` is low from acceptance until after `done`. A command held valid while the engine is busy is not taken and has no effect.
- R10: `done` lasts one cycle. The error flags are 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_kind | input | 2 | 0 all, 1 by tag ID, 2 illegal, 3 by tag ID and page |
| cmd_user | input | 1 | 1 = issued from user state |
| cmd_epn | input | 20 | Page number of the target address |
| cmd_pid | input | 14 | Search tag ID |
| cmd_sind | input | 1 | Search indirect attribute |
| cmd_sgs | input | 1 | Search guest-state attribute |
| done | output | 1 | One-cycle end-of-command pulse |
| err_illegal | output | 1 | Illegal kind, valid with done |
| err_priv | output | 1 | Privilege fault, valid with done |
| ld_en | input | 1 | Entry write strobe |
| ld_arr | input | 1 | Array select for writes |
| ld_idx | input | 6 | Entry index for writes |
| ld_data | input | 42 | Entry written |
| rd_arr | input | 1 | Array select for reads |
| rd_idx | input | 6 | Entry index for reads |
| rd_data | output | 42 | Entry read (combinational) |

## Verification
Assertions check the following on every cycle:
- a whole-array clear leaves no valid bit set;
- a single clear alters only the valid bit of its target;
- no clear ever lands on a protected entry, or on a tag mismatch in kind 1;
- refused commands end at once with the right flag;
- `done` is a single-cycle pulse, and the handshake drops while the engine is busy.

Other behaviours only the bench's scenarios can show. These are which entries survive each mode, the wildcard tag ID, size-code masking, set selection by the address, and the exact walk length. To show them, the bench reloads a known population before each command, counts the survivors and reads chosen entries back.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  localparam int TID_W = 14;
  localparam int PSZ_W = 4;
  localparam int EPN_W = 20;
  localparam int ENT_W = 4 + TID_W + PSZ_W + EPN_W;

  typedef struct packed {
    logic             valid;
    logic             iprot;
    logic             ind;
    logic             tgs;
    logic [TID_W-1:0] tid;
    logic [PSZ_W-1:0] psize;
    logic [EPN_W-1:0] epn;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    KIND_ALL  = 2'd0,
    KIND_PID  = 2'd1,
    KIND_RSVD = 2'd2,
    KIND_PAGE = 2'd3
  } inv_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
(
  input  tlb_ent_t         ent,
  input  logic             by_page,
  input  logic [TID_W-1:0] pid,
  input  logic [EPN_W-1:0] epn,
  input  logic             sind,
  input  logic             sgs,
  output logic             hit
);
  logic [EPN_W-1:0] pmask;
  logic             tid_eq;
  logic             page_hit;

  always_comb begin
    // size code s spans 2^s pages: ignore the low s page bits
    pmask    = ~((EPN_W'(1) << ent.psize) - EPN_W'(1));
    tid_eq   = (ent.tid == pid);
    page_hit = ent.valid
             && (tid_eq || (ent.tid == '0))
             && ((ent.epn & pmask) == (epn & pmask))
             && (ent.ind == sind)
             && (ent.tgs == sgs);
    hit      = !ent.iprot && (by_page ? page_hit : tid_eq);
  end
endmodule

// File: rtl/tlbinv_array.sv
module tlbinv_array
  import tlbinv_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  tlb_ent_t      wr_data,
  input  logic          clr_all,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic [IW-1:0] exam_idx,
  output tlb_ent_t      exam_ent,
  input  logic [IW-1:0] rd_idx,
  output tlb_ent_t      rd_ent
);
  tlb_ent_t mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && wr_idx == IW'(i))
          mem[i] <= wr_data;
        else if (clr_all || (clr_en && clr_idx == IW'(i)))
          mem[i].valid <= 1'b0;
      end
    end
  end

  always_comb begin
    exam_ent = '0;
    rd_ent   = '0;
    for (int i = 0; i < N; i++) begin
      if (exam_idx == IW'(i)) exam_ent = mem[i];
      if (rd_idx == IW'(i))   rd_ent   = mem[i];
    end
  end

  // ---- checks ----
  logic [N-1:0]  vbits;
  logic [IW-1:0] last_clr;
  tlb_ent_t      clr_view;
  tlb_ent_t      last_view;

  always_comb begin
    clr_view  = '0;
    last_view = '0;
    for (int i = 0; i < N; i++) begin
      vbits[i] = mem[i].valid;
      if (clr_idx == IW'(i))  clr_view  = mem[i];
      if (last_clr == IW'(i)) last_view = mem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_clr <= '0;
    else        last_clr <= clr_idx;
  end

  assert_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !wr_en) |=> (vbits == '0));

  assert_only_valid_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !clr_all && !wr_en) |=>
      (last_view == {1'b0, $past(clr_view[ENT_W-2:0])}));
endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker
  import tlbinv_pkg::*;
#(
  parameter int A0_WAYS = 4,
  parameter int A0_SETS = 16,
  parameter int A1_N    = 16,
  parameter int IW      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_user,
  input  logic [EPN_W-1:0] cmd_epn,
  input  logic [TID_W-1:0] cmd_pid,
  input  logic             cmd_sind,
  input  logic             cmd_sgs,
  output logic             clr_all,
  output logic             walking,
  output logic             in_arr1,
  output logic [IW-1:0]    idx0,
  output logic [IW-1:0]    idx1,
  output logic             by_page,
  output logic [TID_W-1:0] pid_q,
  output logic [EPN_W-1:0] epn_q,
  output logic             sind_q,
  output logic             sgs_q,
  output logic             done,
  output logic             err_illegal,
  output logic             err_priv
);
  localparam int A0_N  = A0_WAYS * A0_SETS;
  localparam int SET_W = $clog2(A0_SETS);

  walk_st_e      st;
  logic [IW-1:0] cnt;
  logic          ill_q, priv_q;
  logic          fire, refuse, last0, last1;
  logic [IW-1:0] set_base;

  assign cmd_ready = (st == ST_IDLE);
  assign fire      = cmd_valid && cmd_ready;
  assign refuse    = cmd_user || (cmd_kind == KIND_RSVD);
  assign clr_all   = fire && !refuse && (cmd_kind == KIND_ALL);
  assign walking   = (st == ST_WALK);
  assign done      = (st == ST_FIN);
  assign err_illegal = done && ill_q;
  assign err_priv    = done && priv_q;

  assign set_base = IW'(epn_q[SET_W-1:0]) * IW'(A0_WAYS);
  assign idx0     = by_page ? set_base + cnt : cnt;
  assign idx1     = cnt;
  assign last0    = by_page ? (cnt == IW'(A0_WAYS - 1)) : (cnt == IW'(A0_N - 1));
  assign last1    = (cnt == IW'(A1_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      in_arr1 <= 1'b0;
      by_page <= 1'b0;
      pid_q   <= '0;
      epn_q   <= '0;
      sind_q  <= 1'b0;
      sgs_q   <= 1'b0;
      ill_q   <= 1'b0;
      priv_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (fire) begin
          priv_q  <= cmd_user;
          ill_q   <= !cmd_user && (cmd_kind == KIND_RSVD);
          cnt     <= '0;
          in_arr1 <= 1'b0;
          by_page <= (cmd_kind == KIND_PAGE);
          pid_q   <= cmd_pid;
          epn_q   <= cmd_epn;
          sind_q  <= cmd_sind;
          sgs_q   <= cmd_sgs;
          st      <= (refuse || cmd_kind == KIND_ALL) ? ST_FIN : ST_WALK;
        end
        ST_WALK: begin
          if (!in_arr1) begin
            if (last0) begin
              in_arr1 <= 1'b1;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (last1) begin
            st <= ST_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!err_illegal && !err_priv));

  assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !cmd_ready);
endmodule

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine
  import tlbinv_pkg::*;
#(
  parameter int A0_WAYS = 4,
  parameter int A0_SETS = 16,
  parameter int A1_N    = 16,
  localparam int A0_N   = A0_WAYS * A0_SETS,
  localparam int IDX_W  = $clog2((A0_N > A1_N) ? A0_N : A1_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_user,
  input  logic [19:0]      cmd_epn,
  input  logic [13:0]      cmd_pid,
  input  logic             cmd_sind,
  input  logic             cmd_sgs,
  output logic             done,
  output logic             err_illegal,
  output logic             err_priv,
  input  logic             ld_en,
  input  logic             ld_arr,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [41:0]      ld_data,
  input  logic             rd_arr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [41:0]      rd_data
);
  logic             clr_all, walking, in_arr1, by_page, sind_q, sgs_q, hit;
  logic [IDX_W-1:0] idx0, idx1;
  logic [TID_W-1:0] pid_q;
  logic [EPN_W-1:0] epn_q;
  tlb_ent_t         ex0, ex1, exam, rd0, rd1;
  logic             clr0, clr1;

  tlbinv_walker #(
    .A0_WAYS(A0_WAYS), .A0_SETS(A0_SETS), .A1_N(A1_N), .IW(IDX_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_user(cmd_user), .cmd_epn(cmd_epn), .cmd_pid(cmd_pid),
    .cmd_sind(cmd_sind), .cmd_sgs(cmd_sgs),
    .clr_all(clr_all), .walking(walking), .in_arr1(in_arr1),
    .idx0(idx0), .idx1(idx1), .by_page(by_page), .pid_q(pid_q),
    .epn_q(epn_q), .sind_q(sind_q), .sgs_q(sgs_q),
    .done(done), .err_illegal(err_illegal), .err_priv(err_priv)
  );

  assign exam = in_arr1 ? ex1 : ex0;

  tlbinv_match u_match (
    .ent(exam), .by_page(by_page), .pid(pid_q), .epn(epn_q),
    .sind(sind_q), .sgs(sgs_q), .hit(hit)
  );

  assign clr0 = walking && !in_arr1 && hit;
  assign clr1 = walking &&  in_arr1 && hit;

  tlbinv_array #(.N(A0_N), .IW(IDX_W)) u_arr0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_en && !ld_arr), .wr_idx(ld_idx), .wr_data(ld_data),
    .clr_all(clr_all), .clr_en(clr0), .clr_idx(idx0),
    .exam_idx(idx0), .exam_ent(ex0), .rd_idx(rd_idx), .rd_ent(rd0)
  );

  tlbinv_array #(.N(A1_N), .IW(IDX_W)) u_arr1 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_en && ld_arr), .wr_idx(ld_idx), .wr_data(ld_data),
    .clr_all(clr_all), .clr_en(clr1), .clr_idx(idx1),
    .exam_idx(idx1), .exam_ent(ex1), .rd_idx(rd_idx), .rd_ent(rd1)
  );

  assign rd_data = rd_arr ? rd1 : rd0;

  logic fire;
  assign fire = cmd_valid && cmd_ready;

  assert_priv_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_user) |=> (done && err_priv && !err_illegal));

  assert_illegal_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cmd_user && cmd_kind == 2'd2) |=> (done && err_illegal && !err_priv));

  assert_refused_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cmd_user || cmd_kind == 2'd2)) |-> !clr_all);

  assert_keep_protected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 || clr1) |-> !exam.iprot);

  assert_pid_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr0 || clr1) && !by_page) |-> (exam.tid == pid_q));
endmodule

// File: tb/tlb_inval_engine_tb.sv
`timescale 1ns/100ps
module tlb_inval_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_user = 1'b0, cmd_sind = 1'b0, cmd_sgs = 1'b0;
  logic [1:0]  cmd_kind = '0;
  logic [19:0] cmd_epn = '0;
  logic [13:0] cmd_pid = '0;
  logic        cmd_ready, done, err_illegal, err_priv;
  logic        ld_en = 1'b0, ld_arr = 1'b0, rd_arr = 1'b0;
  logic [5:0]  ld_idx = '0, rd_idx = '0;
  logic [41:0] ld_data = '0, rd_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tlb_inval_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_user(cmd_user), .cmd_epn(cmd_epn), .cmd_pid(cmd_pid),
    .cmd_sind(cmd_sind), .cmd_sgs(cmd_sgs), .done(done), .err_illegal(err_illegal),
    .err_priv(err_priv), .ld_en(ld_en), .ld_arr(ld_arr), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_arr(rd_arr), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [41:0] mk(input logic v, ip, ind, tgs,
                                     input logic [13:0] tid, input logic [3:0] ps,
                                     input logic [19:0] epn);
    return {v, ip, ind, tgs, tid, ps, epn};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ld(input logic arr, input int idx, input logic [41:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_arr = arr; ld_idx = 6'(idx); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic rd(input logic arr, input int idx, output logic [41:0] d);
    rd_arr = arr; rd_idx = 6'(idx);
    #0.1;
    d = rd_data;
  endtask

  task automatic count_valid(output int n);
    logic [41:0] d;
    n = 0;
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < ((a == 0) ? 64 : 16); i++) begin
        rd(a[0], i, d);
        if (d[41]) n++;
      end
  endtask

  // known population: 10 valid entries
  task automatic reload();
    for (int i = 0; i < 64; i++) ld(1'b0, i, '0);
    for (int i = 0; i < 16; i++) ld(1'b1, i, '0);
    ld(1'b0, 20, mk(1, 0, 0, 0, 14'd7, 4'd0, 20'h00005));
    ld(1'b0, 21, mk(1, 1, 0, 0, 14'd7, 4'd0, 20'h00005));
    ld(1'b0, 22, mk(1, 0, 0, 0, 14'd0, 4'd0, 20'h00005));
    ld(1'b0, 23, mk(1, 0, 0, 0, 14'd7, 4'd0, 20'h00015));
    ld(1'b0,  8, mk(1, 0, 0, 0, 14'd9, 4'd0, 20'h00002));
    ld(1'b1,  0, mk(1, 0, 1, 0, 14'd7, 4'd0, 20'h00005));
    ld(1'b1,  1, mk(1, 0, 0, 0, 14'd7, 4'd4, 20'h00000));
    ld(1'b1,  2, mk(1, 0, 0, 1, 14'd7, 4'd0, 20'h00005));
    ld(1'b1,  3, mk(1, 0, 0, 0, 14'd3, 4'd0, 20'h00005));
    ld(1'b1,  4, mk(1, 1, 0, 0, 14'd7, 4'd0, 20'h12345));
  endtask

  task automatic run_cmd(input logic [1:0] k, input logic u, input logic [19:0] e,
                         input logic [13:0] p, input logic s, input logic g,
                         output int lat, output logic ill, output logic pv);
    @(negedge clk);
    cmd_kind = k; cmd_user = u; cmd_epn = e; cmd_pid = p; cmd_sind = s; cmd_sgs = g;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (lat < 200) begin
      lat++;
      if (done) break;
      @(negedge clk);
    end
    ill = err_illegal;
    pv  = err_priv;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  kind;
    logic        user;
    logic [19:0] epn;
    logic [13:0] pid;
    logic        sind;
    logic        sgs;
    logic        e_ill;
    logic        e_priv;
    logic [7:0]  e_lat;
    logic [7:0]  e_cnt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  2'd0, 1'b0, 20'h0, 14'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  8'd0},  // R2 all, protected too
    '{4'd3,  2'd1, 1'b0, 20'h0, 14'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'd81, 8'd5},  // R3 tag 7
    '{4'd4,  2'd3, 1'b0, 20'h5, 14'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'd21, 8'd7},  // R4 page, wildcard, size
    '{4'd4,  2'd3, 1'b0, 20'h5, 14'd7, 1'b1, 1'b0, 1'b0, 1'b0, 8'd21, 8'd9},  // R4 indirect match
    '{4'd4,  2'd3, 1'b0, 20'h5, 14'd7, 1'b0, 1'b1, 1'b0, 1'b0, 8'd21, 8'd9},  // R4 guest match
    '{4'd6,  2'd2, 1'b0, 20'h5, 14'd7, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1,  8'd10}, // R6 illegal
    '{4'd7,  2'd0, 1'b1, 20'h0, 14'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  8'd10}, // R7 user
    '{4'd3,  2'd1, 1'b0, 20'h0, 14'd9, 1'b0, 1'b0, 1'b0, 1'b0, 8'd81, 8'd9},  // R3 tag 9
    '{4'd4,  2'd3, 1'b0, 20'h5, 14'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd21, 8'd8},  // R4 tag 3
    '{4'd3,  2'd1, 1'b0, 20'h0, 14'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd81, 8'd9},  // R3 tag 0 exact
    '{4'd7,  2'd2, 1'b1, 20'h5, 14'd7, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  8'd10}  // R7 over illegal
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int          lat, n;
    logic        ill, pv, seen_ready;
    logic [41:0] d;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", cmd_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 flags", {err_illegal, err_priv}, 0);
    count_valid(n);
    chk("R1 valid count", n, 0);

    for (int v = 0; v < NV; v++) begin
      reload();
      run_cmd(VECS[v].kind, VECS[v].user, VECS[v].epn, VECS[v].pid,
              VECS[v].sind, VECS[v].sgs, lat, ill, pv);
      chk($sformatf("R%0d vec%0d latency", VECS[v].req, v), lat, VECS[v].e_lat);
      chk($sformatf("R%0d vec%0d illegal", VECS[v].req, v), ill, VECS[v].e_ill);
      chk($sformatf("R%0d vec%0d priv", VECS[v].req, v), pv, VECS[v].e_priv);
      count_valid(n);
      chk($sformatf("R%0d vec%0d survivors", VECS[v].req, v), n, VECS[v].e_cnt);
    end

    // R8: cleared entries keep all other fields, protected entry untouched
    reload();
    run_cmd(2'd3, 1'b0, 20'h5, 14'd7, 1'b0, 1'b0, lat, ill, pv);
    rd(1'b0, 20, d);
    chk("R8 cleared entry fields", d, mk(0, 0, 0, 0, 14'd7, 4'd0, 20'h00005));
    rd(1'b1, 1, d);
    chk("R8 cleared sized entry", d, mk(0, 0, 0, 0, 14'd7, 4'd4, 20'h00000));
    rd(1'b0, 21, d);
    chk("R4 protected entry kept", d, mk(1, 1, 0, 0, 14'd7, 4'd0, 20'h00005));

    // R5: a matching entry stored outside the addressed set is not examined
    reload();
    ld(1'b0, 24, mk(1, 0, 0, 0, 14'd7, 4'd0, 20'h00005));
    run_cmd(2'd3, 1'b0, 20'h5, 14'd7, 1'b0, 1'b0, lat, ill, pv);
    chk("R5 latency", lat, 21);
    rd(1'b0, 24, d);
    chk("R5 other set kept", d[41], 1);
    count_valid(n);
    chk("R5 survivors", n, 8);

    // R9 / R10: busy engine ignores a held command; done is one cycle
    reload();
    @(negedge clk);
    cmd_kind = 2'd1; cmd_user = 1'b0; cmd_pid = 14'd9; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_kind = 2'd0;
    seen_ready = 1'b0;
    for (int c = 0; c < 10; c++) begin
      if (cmd_ready) seen_ready = 1'b1;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R9 ready low while busy", seen_ready, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R9 ready after done", cmd_ready, 1);
    count_valid(n);
    chk("R9 held command ignored", n, 9);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule